// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor front end and a cache controller. It holds every in-flight memory request, indexed by the cache line it touches. Requests fall into two groups. Loads and instruction fetches go into a read table. Stores and read-modify-writes go into a write table. Each table is a small fully associative match array that stores the line address, a payload and an issue timestamp for each entry.

A new request enters through a valid/ready handshake. Ready is computed in the same cycle from the request itself and the current table state. A request is held off in four cases:

- the total number of outstanding requests has reached the configured limit;
- its line is already held in either table;
- its byte range does not fit inside one line;
- its length is zero.

A held-off request is not queued. The front end keeps valid high, or withdraws the request, as it chooses. When a request is accepted, the block returns its ID in the same cycle. One cycle later it emits a registered issue message toward the cache. That message side has no back-pressure: the cache request queue must take one message per cycle.

A completion names a line and says which table to search. A read completion returns the requested bytes from the supplied line, right-aligned. A write completion returns the supplied line with the stored request bytes merged in at the request's offset. In both cases the matching entry is retired and its latency is reported. A watchdog inspects entry ages once every threshold period while the tables are non-empty, and latches a deadlock flag when any entry has grown too old.

Top module: `mrt_tracker`

## Requirements
- R1: `req_ready` is 0 whenever MAX_OUT requests (default 4) are outstanding across both tables. Retiring an entry frees its slot for a new request.
- R2: `req_ready` is 0 when the request's line (`req_addr` above the low OFF_W offset bits) is held in either table, whatever its offset or type.
- R3: The 2-bit `req_type` encodes fetch=0, load=1, store=2, read-modify-write=3. Types 0 and 1 occupy the read table and must be completed with `cpl_wr`=0. Types 2 and 3 occupy the write table and must be completed with `cpl_wr`=1.
- R4: The outstanding total rises by one for each accepted request and falls by one for each retired entry. It never exceeds MAX_OUT.
- R5: A request is refused when `req_len` is 0, or when its offset plus `req_len` exceeds LINE_BYTES (default 8).
- R6: While any entry is outstanding, the watchdog runs an age check once every DL_THRESH cycles, counted from when the tables last became non-empty. If any entry's age (current time minus issue time) is at least DL_THRESH, `dl_flag` rises. `dl_flag` stays high until reset. For a single stuck request accepted at edge A, `dl_flag` rises at edge A+DL_THRESH.
- R7: The issue message appears one cycle after acceptance and carries the line, offset and length.
  - `iss_class` is fetch=0, load=1, store=2, atomic=3, from types 0 to 3 respectively.
  - `req_mode` encodes user=0, supervisor=1, device=2. `iss_super` is 1 only for supervisor; device is forwarded as user.
- R8: A read completion returns line bytes offset..offset+len-1 in `rsp_data` bytes 0..len-1. Higher bytes are zero.
- R9: A write completion returns `cpl_data` with bytes offset..offset+len-1 replaced by request data bytes 0..len-1.
- R10: `rsp_lat` is the number of clock edges from acceptance to completion. `rsp_lat_vld` is high only when that value is nonzero.
- R11: IDs start at 0 after reset and increase by one per accepted request only. The ID is presented on `acc_id` during the accepting cycle and returned on `rsp_id`.
- R12: A completion with no matching line in the named table pulses `cpl_err` in the next cycle, gives no response, and changes no table state.
- R13: After reset both tables are empty, `dl_flag`, `iss_valid`, `rsp_valid` and `cpl_err` are 0, and a legal request sees `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Physical byte address |
| req_type | input | 2 | Request type |
| req_mode | input | 2 | Access mode |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | LINE_BYTES*8 | Store data, right-aligned |
| acc_id | output | ID_W | ID given to the request accepted this cycle |
| iss_valid | output | 1 | Issue message valid |
| iss_line | output | ADDR_W-OFF_W | Issued line address |
| iss_off | output | OFF_W | Issued byte offset |
| iss_len | output | LEN_W | Issued length |
| iss_class | output | 2 | Cache request class |
| iss_super | output | 1 | Supervisor access |
| cpl_valid | input | 1 | Completion present |
| cpl_wr | input | 1 | Completion targets the write table |
| cpl_line | input | ADDR_W-OFF_W | Completed line address |
| cpl_data | input | LINE_BYTES*8 | Line buffer from the cache |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | ID_W | ID of the retired request |
| rsp_data | output | LINE_BYTES*8 | Extracted bytes or merged line |
| rsp_lat | output | TS_W | Issue-to-completion latency |
| rsp_lat_vld | output | 1 | Latency is nonzero |
| cpl_err | output | 1 | Completion matched no entry |
| dl_flag | output | 1 | Deadlock detected (sticky) |

## Verification
Several properties are checked on every cycle:

- the outstanding total stays within its bound and moves by exactly one per insert or retirement;
- the issue class and user/supervisor mapping follow the request accepted the cycle before;
- accepted requests always fit inside a line;
- a response and an error never occur together;
- the deadlock flag never falls.

Other behaviours only show up in the bench's scenarios:

- the byte extraction and merge at various offsets and lengths;
- refusal of same-line requests and requests beyond capacity;
- refusal of wrong-table completions without any state change;
- ID sequencing;
- the exact edge on which the watchdog fires.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  typedef enum logic [1:0] {
    RQ_FETCH = 2'd0,
    RQ_LOAD  = 2'd1,
    RQ_STORE = 2'd2,
    RQ_RMW   = 2'd3
  } rq_kind_e;

  typedef enum logic [1:0] {
    CC_FETCH  = 2'd0,
    CC_LOAD   = 2'd1,
    CC_STORE  = 2'd2,
    CC_ATOMIC = 2'd3
  } cc_class_e;

  typedef enum logic [1:0] {
    AM_USER   = 2'd0,
    AM_SUPER  = 2'd1,
    AM_DEVICE = 2'd2,
    AM_RSVD   = 2'd3
  } am_mode_e;

  function automatic cc_class_e to_class(rq_kind_e k);
    case (k)
      RQ_FETCH: return CC_FETCH;
      RQ_LOAD:  return CC_LOAD;
      RQ_STORE: return CC_STORE;
      default:  return CC_ATOMIC;
    endcase
  endfunction

  function automatic logic uses_wr_table(rq_kind_e k);
    return (k == RQ_STORE) || (k == RQ_RMW);
  endfunction

  // device and reserved modes travel as user mode
  function automatic logic is_super(am_mode_e m);
    return m == AM_SUPER;
  endfunction

endpackage

// File: rtl/mrt_table.sv
module mrt_table #(
  parameter int N      = 4,
  parameter int LW     = 13,
  parameter int PW     = 15,
  parameter int TS_W   = 16,
  parameter int THRESH = 32,
  localparam int CW    = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_en,
  input  logic [LW-1:0]   ins_line,
  input  logic [PW-1:0]   ins_pay,
  input  logic [TS_W-1:0] now,
  input  logic [LW-1:0]   probe_line,
  output logic            probe_hit,
  input  logic            rm_en,
  input  logic [LW-1:0]   rm_line,
  output logic            rm_hit,
  output logic [PW-1:0]   rm_pay,
  output logic [TS_W-1:0] rm_ts,
  output logic            old_any,
  output logic [CW-1:0]   occ
);
  localparam logic [TS_W-1:0] THR = TS_W'(THRESH);

  logic [N-1:0]    vld;
  logic [LW-1:0]   line_q [N];
  logic [PW-1:0]   pay_q  [N];
  logic [TS_W-1:0] ts_q   [N];
  logic [N-1:0]    ins_sel, rm_sel;

  always_comb begin
    logic taken;
    taken     = 1'b0;
    probe_hit = 1'b0;
    old_any   = 1'b0;
    rm_pay    = '0;
    rm_ts     = '0;
    occ       = '0;
    for (int i = 0; i < N; i++) begin
      ins_sel[i] = !vld[i] && !taken;
      taken      = taken | !vld[i];
      rm_sel[i]  = vld[i] && (line_q[i] == rm_line);
      if (vld[i] && (line_q[i] == probe_line)) probe_hit = 1'b1;
      if (vld[i] && ((now - ts_q[i]) >= THR)) old_any = 1'b1;
      if (rm_sel[i]) begin
        rm_pay = rm_pay | pay_q[i];
        rm_ts  = rm_ts | ts_q[i];
      end
      occ = occ + CW'(vld[i]);
    end
  end

  assign rm_hit = |rm_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < N; i++) begin
        line_q[i] <= '0;
        pay_q[i]  <= '0;
        ts_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rm_en && rm_sel[i]) vld[i] <= 1'b0;
        if (ins_en && ins_sel[i]) begin
          vld[i]    <= 1'b1;
          line_q[i] <= ins_line;
          pay_q[i]  <= ins_pay;
          ts_q[i]   <= now;
        end
      end
    end
  end

endmodule

// File: rtl/mrt_lanes.sv
module mrt_lanes #(
  parameter int LB    = 8,
  localparam int OW   = $clog2(LB),
  localparam int LENW = $clog2(LB + 1),
  localparam int DW   = LB * 8
) (
  input  logic [DW-1:0]   line,
  input  logic [OW-1:0]   off,
  input  logic [LENW-1:0] len,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_bytes,
  output logic [DW-1:0]   merged
);
  logic [DW-1:0]   shifted, wsh;
  logic [LENW:0]   off_x, len_x, end_x;

  assign shifted = line >> {off, 3'b000};
  assign wsh     = wdata << {off, 3'b000};
  assign off_x   = (LENW + 1)'(off);
  assign len_x   = {1'b0, len};
  assign end_x   = off_x + len_x;

  for (genvar b = 0; b < LB; b++) begin : g_byte
    localparam logic [LENW:0] BI = (LENW + 1)'(b);
    assign rd_bytes[b*8 +: 8] = (BI < len_x) ? shifted[b*8 +: 8] : 8'h00;
    assign merged[b*8 +: 8]   = (BI >= off_x && BI < end_x) ? wsh[b*8 +: 8]
                                                            : line[b*8 +: 8];
  end

endmodule

// File: rtl/mrt_watchdog.sv
module mrt_watchdog #(
  parameter int THRESH = 32,
  localparam int CW    = $clog2(THRESH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic old_any,
  output logic dl_flag
);
  logic [CW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      dl_flag <= 1'b0;
    end else if (!busy) begin
      tick <= '0;
    end else if (tick == CW'(THRESH - 1)) begin
      tick <= '0;
      if (old_any) dl_flag <= 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

endmodule

// File: rtl/mrt_tracker.sv
module mrt_tracker #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int MAX_OUT    = 4,
  parameter int ID_W       = 8,
  parameter int TS_W       = 16,
  parameter int DL_THRESH  = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LEN_W     = $clog2(LINE_BYTES + 1),
  localparam int DW        = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_type,
  input  logic [1:0]        req_mode,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DW-1:0]     req_wdata,
  output logic [ID_W-1:0]   acc_id,
  output logic              iss_valid,
  output logic [LA_W-1:0]   iss_line,
  output logic [OFF_W-1:0]  iss_off,
  output logic [LEN_W-1:0]  iss_len,
  output logic [1:0]        iss_class,
  output logic              iss_super,
  input  logic              cpl_valid,
  input  logic              cpl_wr,
  input  logic [LA_W-1:0]   cpl_line,
  input  logic [DW-1:0]     cpl_data,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DW-1:0]     rsp_data,
  output logic [TS_W-1:0]   rsp_lat,
  output logic              rsp_lat_vld,
  output logic              cpl_err,
  output logic              dl_flag
);
  import mrt_pkg::*;

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int RPW   = ID_W + OFF_W + LEN_W;
  localparam int WPW   = RPW + DW;

  logic [LA_W-1:0]  req_line;
  logic [OFF_W-1:0] req_off;
  rq_kind_e         kind;
  logic             to_wr, legal, room, acc, retire, hit_any;
  logic             ph_r, ph_w, rh_r, rh_w, old_r, old_w;
  logic [CNT_W-1:0] occ_r, occ_w, occ_tot;
  logic [ID_W-1:0]  id_q;
  logic [TS_W-1:0]  now_q;
  logic [RPW-1:0]   rpay_out;
  logic [WPW-1:0]   wpay_out;
  logic [TS_W-1:0]  ts_r, ts_w, sel_ts;
  logic [ID_W-1:0]  r_id, w_id, sel_id;
  logic [OFF_W-1:0] r_off, w_off, sel_off;
  logic [LEN_W-1:0] r_len, w_len, sel_len;
  logic [DW-1:0]    w_dat, rd_bytes, merged;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign kind     = rq_kind_e'(req_type);
  assign to_wr    = uses_wr_table(kind);
  assign legal    = (req_len != '0) &&
                    (((LEN_W + 1)'(req_off) + {1'b0, req_len}) <= (LEN_W + 1)'(LINE_BYTES));
  assign occ_tot  = occ_r + occ_w;
  assign room     = occ_tot < CNT_W'(MAX_OUT);
  assign req_ready = room && !ph_r && !ph_w && legal;
  assign acc      = req_valid && req_ready;
  assign acc_id   = id_q;
  assign hit_any  = cpl_wr ? rh_w : rh_r;
  assign retire   = cpl_valid && hit_any;

  mrt_table #(.N(MAX_OUT), .LW(LA_W), .PW(RPW), .TS_W(TS_W), .THRESH(DL_THRESH)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ins_en(acc && !to_wr), .ins_line(req_line), .ins_pay({id_q, req_off, req_len}),
    .now(now_q), .probe_line(req_line), .probe_hit(ph_r),
    .rm_en(cpl_valid && !cpl_wr), .rm_line(cpl_line), .rm_hit(rh_r),
    .rm_pay(rpay_out), .rm_ts(ts_r), .old_any(old_r), .occ(occ_r)
  );

  mrt_table #(.N(MAX_OUT), .LW(LA_W), .PW(WPW), .TS_W(TS_W), .THRESH(DL_THRESH)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .ins_en(acc && to_wr), .ins_line(req_line), .ins_pay({id_q, req_off, req_len, req_wdata}),
    .now(now_q), .probe_line(req_line), .probe_hit(ph_w),
    .rm_en(cpl_valid && cpl_wr), .rm_line(cpl_line), .rm_hit(rh_w),
    .rm_pay(wpay_out), .rm_ts(ts_w), .old_any(old_w), .occ(occ_w)
  );

  assign {r_id, r_off, r_len}        = rpay_out;
  assign {w_id, w_off, w_len, w_dat} = wpay_out;
  assign sel_id  = cpl_wr ? w_id  : r_id;
  assign sel_off = cpl_wr ? w_off : r_off;
  assign sel_len = cpl_wr ? w_len : r_len;
  assign sel_ts  = cpl_wr ? ts_w  : ts_r;

  mrt_lanes #(.LB(LINE_BYTES)) u_lanes (
    .line(cpl_data), .off(sel_off), .len(sel_len), .wdata(w_dat),
    .rd_bytes(rd_bytes), .merged(merged)
  );

  mrt_watchdog #(.THRESH(DL_THRESH)) u_wd (
    .clk(clk), .rst_n(rst_n), .busy(occ_tot != '0),
    .old_any(old_r || old_w), .dl_flag(dl_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q        <= '0;
      now_q       <= '0;
      iss_valid   <= 1'b0;
      iss_line    <= '0;
      iss_off     <= '0;
      iss_len     <= '0;
      iss_class   <= '0;
      iss_super   <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_id      <= '0;
      rsp_data    <= '0;
      rsp_lat     <= '0;
      rsp_lat_vld <= 1'b0;
      cpl_err     <= 1'b0;
    end else begin
      now_q     <= now_q + 1'b1;
      iss_valid <= acc;
      if (acc) begin
        id_q      <= id_q + 1'b1;
        iss_line  <= req_line;
        iss_off   <= req_off;
        iss_len   <= req_len;
        iss_class <= to_class(kind);
        iss_super <= is_super(am_mode_e'(req_mode));
      end
      rsp_valid   <= retire;
      rsp_lat_vld <= retire && ((now_q - sel_ts) != '0);
      cpl_err     <= cpl_valid && !hit_any;
      if (retire) begin
        rsp_id   <= sel_id;
        rsp_data <= cpl_wr ? merged : rd_bytes;
        rsp_lat  <= now_q - sel_ts;
      end
    end
  end

endmodule

// File: rtl/mrt_tracker_chk.sv
module mrt_tracker_chk #(
  parameter int MAX_OUT    = 4,
  parameter int LINE_BYTES = 8,
  parameter int CNT_W      = 3,
  parameter int OFF_W      = 3,
  parameter int LEN_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             retire,
  input logic [CNT_W-1:0] occ_tot,
  input logic [1:0]       req_type,
  input logic [1:0]       req_mode,
  input logic [OFF_W-1:0] req_off,
  input logic [LEN_W-1:0] req_len,
  input logic             iss_valid,
  input logic [1:0]       iss_class,
  input logic             iss_super,
  input logic             rsp_valid,
  input logic             rsp_lat_vld,
  input logic             cpl_err,
  input logic             dl_flag
);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_tot <= CNT_W'(MAX_OUT));
  // R4
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !retire |=> occ_tot == $past(occ_tot) + CNT_W'(1));
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire && !acc |=> occ_tot == $past(occ_tot) - CNT_W'(1));
  // R7
  class_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_class == $past(req_type));
  // R7
  mode_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_super == ($past(req_mode) == 2'd1));
  // R5
  legal_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (req_len != '0) && (int'(req_off) + int'(req_len) <= LINE_BYTES));
  // R12
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && cpl_err));
  // R6
  dl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_flag |=> dl_flag);
  // R10
  lat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_lat_vld);
endmodule

bind mrt_tracker mrt_tracker_chk #(
  .MAX_OUT(MAX_OUT), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .retire(retire), .occ_tot(occ_tot),
  .req_type(req_type), .req_mode(req_mode), .req_off(req_off), .req_len(req_len),
  .iss_valid(iss_valid), .iss_class(iss_class), .iss_super(iss_super),
  .rsp_valid(rsp_valid), .rsp_lat_vld(rsp_lat_vld), .cpl_err(cpl_err), .dl_flag(dl_flag)
);

// File: tb/sim_mrt_tracker.sv
module sim_mrt_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int THR = 32;
  localparam logic [63:0] IMG = 64'h8877665544332211;

  // {type, off, len, wdata, expected response}
  localparam logic [136:0] VEC [8] = '{
    {2'd1, 3'd0, 4'd1, 64'h0,      64'h11},
    {2'd1, 3'd2, 4'd3, 64'h0,      64'h554433},
    {2'd0, 3'd0, 4'd8, 64'h0,      64'h8877665544332211},
    {2'd1, 3'd7, 4'd1, 64'h0,      64'h88},
    {2'd2, 3'd0, 4'd2, 64'hBBAA,   64'h887766554433BBAA},
    {2'd2, 3'd5, 4'd3, 64'hEEDDCC, 64'hEEDDCC5544332211},
    {2'd3, 3'd3, 4'd2, 64'h0F0E,   64'h8877660F0E332211},
    {2'd1, 3'd4, 4'd4, 64'h0,      64'h88776655}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0] req_type = '0, req_mode = '0;
  logic [3:0] req_len = 4'd1;
  logic [63:0] req_wdata = '0;
  logic [7:0] acc_id;
  logic iss_valid, iss_super;
  logic [12:0] iss_line;
  logic [2:0] iss_off;
  logic [3:0] iss_len;
  logic [1:0] iss_class;
  logic cpl_valid = 1'b0, cpl_wr = 1'b0;
  logic [12:0] cpl_line = '0;
  logic [63:0] cpl_data = '0;
  logic rsp_valid, rsp_lat_vld, cpl_err, dl_flag;
  logic [7:0] rsp_id;
  logic [63:0] rsp_data;
  logic [15:0] rsp_lat;

  int n_chk = 0, n_fail = 0;
  int exp_id = 0;
  logic [136:0] v;
  bit ok;
  logic [7:0] id;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrt_tracker u0 (.*);

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [12:0] ln, input logic [2:0] of, input logic [1:0] t,
                      input logic [1:0] m, input logic [3:0] l, input logic [63:0] w,
                      output bit rdy, output logic [7:0] aid);
    req_addr = {ln, of}; req_type = t; req_mode = m; req_len = l; req_wdata = w;
    req_valid = 1'b1;
    #1;
    rdy = req_ready; aid = acc_id;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (rdy) exp_id++;
  endtask

  task automatic complete(input bit wr, input logic [12:0] ln, input logic [63:0] d);
    cpl_valid = 1'b1; cpl_wr = wr; cpl_line = ln; cpl_data = d;
    @(posedge clk); #1;
    cpl_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R13 reset state
    check("R13 ready", req_ready, 1);
    check("R13 iss_valid", iss_valid, 0);
    check("R13 rsp_valid", rsp_valid, 0);
    check("R13 cpl_err", cpl_err, 0);
    check("R13 dl_flag", dl_flag, 0);

    // vector table: R8 R9 R10 R11 R7
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      send(13'(16 + k), v[134:132], v[136:135], 2'd0, v[131:128], v[127:64], ok, id);
      check("R5 legal accepted", ok, 1);
      check("R11 id order", id, 8'(exp_id - 1));
      check("R7 issue valid", iss_valid, 1);
      check("R7 class", iss_class, v[136:135]);
      check("R7 line", iss_line, 13'(16 + k));
      check("R7 off/len", {iss_off, iss_len}, {v[134:132], v[131:128]});
      complete(v[136], 13'(16 + k), IMG);
      check("R3 rsp_valid", rsp_valid, 1);
      check(v[136] ? "R9 merge" : "R8 extract", rsp_data, v[63:0]);
      check("R11 rsp_id", rsp_id, 8'(exp_id - 1));
      check("R10 latency", rsp_lat, 1);
      check("R10 lat_vld", rsp_lat_vld, 1);
    end

    // R7 modes
    send(13'd40, 3'd0, 2'd1, 2'd2, 4'd1, 64'h0, ok, id);
    check("R7 device as user", iss_super, 0);
    complete(1'b0, 13'd40, IMG);
    send(13'd41, 3'd0, 2'd2, 2'd1, 4'd1, 64'h77, ok, id);
    check("R7 supervisor", iss_super, 1);
    check("R7 store class", iss_class, 2);
    complete(1'b1, 13'd41, IMG);

    // R2 same line refused
    send(13'd50, 3'd0, 2'd1, 2'd0, 4'd1, 64'h0, ok, id);
    check("R2 first", ok, 1);
    send(13'd50, 3'd4, 2'd2, 2'd0, 4'd1, 64'h0, ok, id);
    check("R2 store same line", ok, 0);
    check("R2 no issue", iss_valid, 0);
    send(13'd50, 3'd1, 2'd0, 2'd0, 4'd1, 64'h0, ok, id);
    check("R2 fetch same line", ok, 0);

    // R1 capacity
    send(13'd51, 3'd0, 2'd1, 2'd0, 4'd1, 64'h0, ok, id);
    send(13'd52, 3'd1, 2'd2, 2'd0, 4'd1, 64'h99, ok, id);
    send(13'd53, 3'd0, 2'd0, 2'd0, 4'd1, 64'h0, ok, id);
    check("R1 fourth accepted", ok, 1);
    send(13'd54, 3'd0, 2'd1, 2'd0, 4'd1, 64'h0, ok, id);
    check("R1 full refused", ok, 0);

    // R12 unknown line
    complete(1'b0, 13'd99, IMG);
    check("R12 err", cpl_err, 1);
    check("R12 no rsp", rsp_valid, 0);
    send(13'd54, 3'd0, 2'd1, 2'd0, 4'd1, 64'h0, ok, id);
    check("R12 state unchanged", ok, 0);

    // R3 wrong table
    complete(1'b0, 13'd52, IMG);
    check("R3 store in read table err", cpl_err, 1);
    complete(1'b1, 13'd50, IMG);
    check("R3 load in write table err", cpl_err, 1);
    complete(1'b1, 13'd52, IMG);
    check("R3 write completion ok", rsp_valid, 1);
    check("R9 merge off1", rsp_data, 64'h8877665544339911);

    // R4 slot freed
    send(13'd54, 3'd0, 2'd1, 2'd0, 4'd1, 64'h0, ok, id);
    check("R4 slot reused", ok, 1);
    check("R11 id after rejects", id, 8'(exp_id - 1));
    complete(1'b0, 13'd50, IMG);
    complete(1'b0, 13'd51, IMG);
    complete(1'b0, 13'd53, IMG);
    complete(1'b0, 13'd54, IMG);
    check("R4 drained rsp", rsp_valid, 1);

    // R5 illegal shapes
    send(13'd70, 3'd0, 2'd1, 2'd0, 4'd0, 64'h0, ok, id);
    check("R5 zero len", ok, 0);
    send(13'd70, 3'd6, 2'd1, 2'd0, 4'd3, 64'h0, ok, id);
    check("R5 crosses line", ok, 0);

    // R6 watchdog
    check("R6 no flag for short lives", dl_flag, 0);
    send(13'd60, 3'd0, 2'd1, 2'd0, 4'd1, 64'h0, ok, id);
    repeat (THR - 1) @(posedge clk);
    #1;
    check("R6 not yet", dl_flag, 0);
    @(posedge clk); #1;
    check("R6 flagged", dl_flag, 1);
    complete(1'b0, 13'd60, IMG);
    check("R10 long latency", rsp_lat, 16'(THR + 1));
    repeat (3) @(posedge clk);
    #1;
    check("R6 sticky", dl_flag, 1);

    finish_run();
  end

endmodule